// File: doc/BRIEF.md
# Eight-Bit ALU with Condition Flags

This block computes results and condition flags for an accumulator-style 8-bit datapath. It is a combinational unit. An operation code, two byte operands and the current condition byte go in. A result byte, a 16-bit word and the next condition byte come out in the same cycle. The 16-bit word carries the multiply product or the sign-extended operand.

Every operation carries its own flag rule. Each flag is written from the result, forced to a constant, or kept from the incoming condition byte. The three system bits (entire-state, fast mask, interrupt mask) are never changed by any operation. A small registered path holds a copy of the condition byte. On every clock edge where the update strobe is high, it loads the next condition byte.

Top module: `alu8_cc_unit`

## Requirements
- R1: Condition byte layout is bit7 E, bit6 F, bit5 H, bit4 I, bit3 N, bit2 Z, bit1 V, bit0 C. For every op_i, bits 7, 6 and 4 of cc_next_o equal those of cc_i. For every operation, N is bit 7 of the result and Z is set when the result is zero, unless a requirement below says otherwise.
- R2: op 0 (add) and op 1 (add with carry, carry-in = cc_i[0]) give res_o = a+b(+cin). C is the carry out of bit 7. V is the carry into bit 7 XOR the carry out of bit 7. H is the carry out of bit 3. N and Z follow the result.
- R3: op 2 (subtract), op 3 (subtract with borrow-in = cc_i[0]) and op 4 (compare) evaluate a-b(-cin). C is set when the unsigned subtrahend plus borrow exceeds a. V is set on signed overflow. H is kept. Compare drives res_o = a_i, and its flags come from the difference.
- R4: ops 5 AND, 6 OR, 7 XOR, 8 bit test (a&b), 9 test (a) and 10 load (b) set N and Z, clear V and keep C. Bit test and test drive res_o = a_i.
- R5: op 11 (clear) gives res_o = 0 and flags N=0, Z=1, V=0, C=0.
- R6: op 12 (complement) gives ~a with V=0 and C=1. op 13 (negate) gives 0-a, with V set only for a=0x80 and C set for every a other than 0.
- R7: op 14 (increment) and op 15 (decrement) change a by one. V is set when a=0x7F (increment) or a=0x80 (decrement). C is kept.
- R8: ops 16 arithmetic left, 17 arithmetic right, 18 logical right, 19 rotate left and 20 rotate right move the shifted-out bit into C. Rotates take the old C in at the vacated end. The logical right shift clears N. The left shift and left rotate set V to a[7]^a[6]. The right shifts and right rotate keep V.
- R9: op 21 (decimal adjust of a) adds 0x06 when H=1 or a[3:0]>9. It adds 0x60 when C=1, or a[7:4]>9, or a[7:4]>8 with a[3:0]>9. C ends as old C OR the high correction. V and H are kept.
- R10: op 23 (multiply) gives prod_o = a*b unsigned and res_o = low byte. Z is set when the whole product is 0. C equals prod_o[7]. N and V are kept.
- R11: op 22 (sign extend of b) gives prod_o = {8{b[7]}, b} and res_o = {8{b[7]}}. N = b[7], Z = (b==0), and V and C are kept.
- R12: cc_q_o resets to 0x50. On a rising clock edge with upd_i=1 it loads cc_next_o. With upd_i=0 it holds.
- R13: Codes 24 to 31 pass a_i to res_o and cc_i to cc_next_o. prod_o is 0 for every operation except 22 and 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cc_i | input | 8 | Current condition byte |
| upd_i | input | 1 | Load strobe for cc_q_o |
| res_o | output | 8 | Result byte |
| prod_o | output | 16 | Product or sign-extended word |
| cc_next_o | output | 8 | Next condition byte |
| cc_q_o | output | 8 | Registered condition byte |

## Verification
res_o, prod_o and cc_next_o have no register in their path and are due in the same cycle as the stimulus. The bench applies each vector just after a falling edge and samples one nanosecond later, well before the next rising edge. cc_q_o is due on the first rising edge after upd_i is seen high. The bench raises the strobe at a falling edge, waits for the rising edge and samples 1 ns after it. It also confirms that the registered value does not move across later edges while the strobe is low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned OPW = 5;

  localparam int unsigned FC = 0;
  localparam int unsigned FV = 1;
  localparam int unsigned FZ = 2;
  localparam int unsigned FN = 3;
  localparam int unsigned FH = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_BIT = 5'd8,  OP_TST = 5'd9,  OP_LD  = 5'd10, OP_CLR = 5'd11,
    OP_COM = 5'd12, OP_NEG = 5'd13, OP_INC = 5'd14, OP_DEC = 5'd15,
    OP_ASL = 5'd16, OP_ASR = 5'd17, OP_LSR = 5'd18, OP_ROL = 5'd19,
    OP_ROR = 5'd20, OP_DAA = 5'd21, OP_SEX = 5'd22, OP_MUL = 5'd23
  } op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o,
  output logic         h_o
);
  localparam int unsigned HB = 4;
  logic [W-1:0] bb;
  logic         ci;
  logic [W:0]   sum;
  logic [HB:0]  hsum;

  always_comb begin
    bb    = sub_i ? ~b_i : b_i;
    ci    = sub_i ? ~cin_i : cin_i;
    sum   = {1'b0, a_i} + {1'b0, bb} + (W+1)'(ci);
    hsum  = {1'b0, a_i[HB-1:0]} + {1'b0, bb[HB-1:0]} + (HB+1)'(ci);
    res_o = sum[W-1:0];
    c_o   = sum[W] ^ sub_i;  // borrow sense on subtract
    v_o   = (a_i[W-1] == bb[W-1]) && (sum[W-1] != a_i[W-1]);
    h_o   = hsum[HB];
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    res_o = a_i;
    c_o   = cin_i;
    v_o   = 1'b0;
    unique case (op_i)
      OP_CLR: res_o = '0;
      OP_COM: res_o = ~a_i;
      OP_NEG: begin
        res_o = '0 - a_i;
        c_o   = |a_i;
        v_o   = (a_i == SMIN);
      end
      OP_INC: begin res_o = a_i + 1'b1; v_o = (a_i == SMAX); end
      OP_DEC: begin res_o = a_i - 1'b1; v_o = (a_i == SMIN); end
      OP_ASL, OP_ROL: begin
        res_o = {a_i[W-2:0], (op_i == OP_ROL) ? cin_i : 1'b0};
        c_o   = a_i[W-1];
        v_o   = a_i[W-1] ^ a_i[W-2];
      end
      OP_ASR: begin res_o = {a_i[W-1], a_i[W-1:1]}; c_o = a_i[0]; end
      OP_LSR: begin res_o = {1'b0, a_i[W-1:1]};     c_o = a_i[0]; end
      OP_ROR: begin res_o = {cin_i, a_i[W-1:1]};    c_o = a_i[0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa (
  input  logic [7:0] a_i,
  input  logic       h_i,
  input  logic       c_i,
  output logic [7:0] res_o,
  output logic       c_o
);
  logic lo_big, hi_big, hi_nine, fix_lo, fix_hi;

  always_comb begin
    lo_big  = a_i[3:0] > 4'd9;
    hi_big  = a_i[7:4] > 4'd9;
    hi_nine = a_i[7:4] > 4'd8;
    fix_lo  = h_i | lo_big;
    fix_hi  = c_i | hi_big | (hi_nine & lo_big);
    res_o   = a_i + {1'b0, fix_hi, fix_hi, 2'b00, fix_lo, fix_lo, 1'b0};
    c_o     = c_i | fix_hi;
  end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;
  logic [PW-1:0] pp [W];

  // shift-and-add partial products
  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b_i[i] ? (PW'(a_i) << i) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++) p_o = p_o + pp[i];
  end
endmodule

// File: rtl/alu8_cc_unit.sv
module alu8_cc_unit
  import alu8_pkg::*;
#(
  parameter logic [7:0] CC_RST = 8'h50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  op_i,
  input  logic [7:0]  a_i,
  input  logic [7:0]  b_i,
  input  logic [7:0]  cc_i,
  input  logic        upd_i,
  output logic [7:0]  res_o,
  output logic [15:0] prod_o,
  output logic [7:0]  cc_next_o,
  output logic [7:0]  cc_q_o
);
  op_e        op;
  logic [7:0] as_res, un_res, daa_res, lv;
  logic       as_c, as_v, as_h, un_c, un_v, daa_c, as_sub, as_cin;
  logic [15:0] mul_p;
  logic [7:0] cc_n;

  assign op     = op_e'(op_i);
  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? cc_i[FC] : 1'b0;

  alu8_addsub #(.W(DW)) u_as (
    .a_i(a_i), .b_i(b_i), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .c_o(as_c), .v_o(as_v), .h_o(as_h)
  );

  alu8_unary #(.W(DW)) u_un (
    .op_i(op), .a_i(a_i), .cin_i(cc_i[FC]),
    .res_o(un_res), .c_o(un_c), .v_o(un_v)
  );

  alu8_daa u_daa (
    .a_i(a_i), .h_i(cc_i[FH]), .c_i(cc_i[FC]), .res_o(daa_res), .c_o(daa_c)
  );

  alu8_mul #(.W(DW)) u_mul (.a_i(a_i), .b_i(b_i), .p_o(mul_p));

  always_comb begin
    res_o  = a_i;
    prod_o = '0;
    cc_n   = cc_i;
    lv     = '0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res_o = as_res;
        cc_n[FH] = as_h;
        cc_n[FN] = as_res[7]; cc_n[FZ] = ~|as_res;
        cc_n[FV] = as_v;      cc_n[FC] = as_c;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        if (op != OP_CMP) res_o = as_res;
        cc_n[FN] = as_res[7]; cc_n[FZ] = ~|as_res;
        cc_n[FV] = as_v;      cc_n[FC] = as_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT, OP_TST, OP_LD: begin
        case (op)
          OP_AND, OP_BIT: lv = a_i & b_i;
          OP_OR:          lv = a_i | b_i;
          OP_XOR:         lv = a_i ^ b_i;
          OP_LD:          lv = b_i;
          default:        lv = a_i;
        endcase
        if (op != OP_BIT && op != OP_TST) res_o = lv;
        cc_n[FN] = lv[7]; cc_n[FZ] = ~|lv; cc_n[FV] = 1'b0;
      end
      OP_CLR, OP_COM, OP_NEG, OP_INC, OP_DEC,
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        res_o = un_res;
        cc_n[FN] = un_res[7]; cc_n[FZ] = ~|un_res;
        case (op)
          OP_CLR:                 begin cc_n[FV] = 1'b0; cc_n[FC] = 1'b0; end
          OP_COM:                 begin cc_n[FV] = 1'b0; cc_n[FC] = 1'b1; end
          OP_NEG, OP_ASL, OP_ROL: begin cc_n[FV] = un_v; cc_n[FC] = un_c; end
          OP_INC, OP_DEC:         cc_n[FV] = un_v;
          default:                cc_n[FC] = un_c;
        endcase
      end
      OP_DAA: begin
        res_o = daa_res;
        cc_n[FN] = daa_res[7]; cc_n[FZ] = ~|daa_res; cc_n[FC] = daa_c;
      end
      OP_SEX: begin
        res_o  = {8{b_i[7]}};
        prod_o = {{8{b_i[7]}}, b_i};
        cc_n[FN] = b_i[7]; cc_n[FZ] = ~|b_i;
      end
      OP_MUL: begin
        res_o  = mul_p[7:0];
        prod_o = mul_p;
        cc_n[FZ] = ~|mul_p; cc_n[FC] = mul_p[7];
      end
      default: ;
    endcase
  end

  assign cc_next_o = cc_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cc_q_o <= CC_RST;
    else if (upd_i) cc_q_o <= cc_n;
  end
endmodule

// File: rtl/alu8_cc_unit_chk.sv
module alu8_cc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  op_i,
  input logic [7:0]  a_i,
  input logic [7:0]  cc_i,
  input logic        upd_i,
  input logic [7:0]  res_o,
  input logic [15:0] prod_o,
  input logic [7:0]  cc_next_o,
  input logic [7:0]  cc_q_o
);
  a_r1_system_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_next_o[7:6] == cc_i[7:6]) && (cc_next_o[4] == cc_i[4]));

  a_r4_logic_c_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 5'd5 && op_i <= 5'd10) |-> (cc_next_o[0] == cc_i[0]) && !cc_next_o[1]);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd11) |-> (res_o == 8'h00) && (cc_next_o[3:0] == 4'b0100));

  a_r6_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd12) |-> (res_o == ~a_i) && (cc_next_o[1:0] == 2'b01));

  a_r8_lsr_n_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd18) |-> !cc_next_o[3] && (cc_next_o[0] == a_i[0]));

  a_r10_mul_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd23) |-> (cc_next_o[0] == prod_o[7]) && (cc_next_o[2] == (prod_o == 16'h0))
                        && (cc_next_o[3] == cc_i[3]));

  a_r12_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (cc_q_o == $past(cc_next_o)));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(cc_q_o));

  a_r13_prod_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 5'd22 && op_i != 5'd23) |-> (prod_o == 16'h0));
endmodule

bind alu8_cc_unit alu8_cc_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .cc_i(cc_i),
  .upd_i(upd_i), .res_o(res_o), .prod_o(prod_o), .cc_next_o(cc_next_o),
  .cc_q_o(cc_q_o)
);

// File: tb/alu8_cc_unit_tb.sv
`timescale 1ns/1ps
module alu8_cc_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  a_i = '0, b_i = '0, cc_i = '0;
  logic        upd_i = 1'b0;
  logic [7:0]  res_o, cc_next_o, cc_q_o;
  logic [15:0] prod_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  alu8_cc_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .cc_i(cc_i), .upd_i(upd_i), .res_o(res_o), .prod_o(prod_o),
    .cc_next_o(cc_next_o), .cc_q_o(cc_q_o)
  );

  // {op, a, b, cc_in, res, cc_next, prod}
  localparam int NV = 37;
  localparam logic [60:0] VEC [NV] = '{
    {5'd0,  8'h08, 8'h08, 8'hD0, 8'h10, 8'hF0, 16'h0000},
    {5'd0,  8'h7F, 8'h01, 8'hD0, 8'h80, 8'hFA, 16'h0000},
    {5'd1,  8'hFF, 8'h00, 8'hD1, 8'h00, 8'hF5, 16'h0000},
    {5'd2,  8'h00, 8'h01, 8'hD0, 8'hFF, 8'hD9, 16'h0000},
    {5'd3,  8'h80, 8'h00, 8'hD1, 8'h7F, 8'hD2, 16'h0000},
    {5'd4,  8'h42, 8'h42, 8'hF0, 8'h42, 8'hF4, 16'h0000},
    {5'd5,  8'hF0, 8'h0F, 8'hD3, 8'h00, 8'hD5, 16'h0000},
    {5'd6,  8'h80, 8'h01, 8'hD2, 8'h81, 8'hD8, 16'h0000},
    {5'd7,  8'hFF, 8'h0F, 8'hD1, 8'hF0, 8'hD9, 16'h0000},
    {5'd8,  8'h55, 8'hAA, 8'hD2, 8'h55, 8'hD4, 16'h0000},
    {5'd9,  8'h80, 8'h00, 8'hD3, 8'h80, 8'hD9, 16'h0000},
    {5'd10, 8'h11, 8'h00, 8'hD8, 8'h00, 8'hD4, 16'h0000},
    {5'd11, 8'h5A, 8'h00, 8'hDB, 8'h00, 8'hD4, 16'h0000},
    {5'd12, 8'h0F, 8'h00, 8'hD0, 8'hF0, 8'hD9, 16'h0000},
    {5'd13, 8'h80, 8'h00, 8'hD0, 8'h80, 8'hDB, 16'h0000},
    {5'd13, 8'h00, 8'h00, 8'hD1, 8'h00, 8'hD4, 16'h0000},
    {5'd14, 8'h7F, 8'h00, 8'hD1, 8'h80, 8'hDB, 16'h0000},
    {5'd15, 8'h00, 8'h00, 8'hD0, 8'hFF, 8'hD8, 16'h0000},
    {5'd15, 8'h80, 8'h00, 8'hD0, 8'h7F, 8'hD2, 16'h0000},
    {5'd16, 8'hC0, 8'h00, 8'hD0, 8'h80, 8'hD9, 16'h0000},
    {5'd16, 8'h40, 8'h00, 8'hD0, 8'h80, 8'hDA, 16'h0000},
    {5'd17, 8'h81, 8'h00, 8'hD2, 8'hC0, 8'hDB, 16'h0000},
    {5'd18, 8'h81, 8'h00, 8'hD8, 8'h40, 8'hD1, 16'h0000},
    {5'd19, 8'h80, 8'h00, 8'hD1, 8'h01, 8'hD3, 16'h0000},
    {5'd20, 8'h01, 8'h00, 8'hD0, 8'h00, 8'hD5, 16'h0000},
    {5'd20, 8'h02, 8'h00, 8'hD1, 8'h81, 8'hD8, 16'h0000},
    {5'd21, 8'h15, 8'h00, 8'hD0, 8'h15, 8'hD0, 16'h0000},
    {5'd21, 8'h9A, 8'h00, 8'hD0, 8'h00, 8'hD5, 16'h0000},
    {5'd21, 8'h12, 8'h00, 8'hF0, 8'h18, 8'hF0, 16'h0000},
    {5'd21, 8'h20, 8'h00, 8'hD1, 8'h80, 8'hD9, 16'h0000},
    {5'd22, 8'h00, 8'h80, 8'hD4, 8'hFF, 8'hD8, 16'hFF80},
    {5'd23, 8'h10, 8'h10, 8'hD0, 8'h00, 8'hD0, 16'h0100},
    {5'd23, 8'h0C, 8'h0B, 8'hDA, 8'h84, 8'hDB, 16'h0084},
    {5'd23, 8'h00, 8'h55, 8'hD1, 8'h00, 8'hD4, 16'h0000},
    {5'd23, 8'hFF, 8'hFF, 8'hD1, 8'h01, 8'hD0, 16'hFE01},
    {5'd24, 8'h33, 8'h44, 8'hD7, 8'h33, 8'hD7, 16'h0000},
    {5'd31, 8'hA5, 8'h00, 8'h2A, 8'hA5, 8'h2A, 16'h0000}
  };

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd1)       return "R2";
    else if (op <= 5'd4)  return "R3";
    else if (op <= 5'd10) return "R4";
    else if (op == 5'd11) return "R5";
    else if (op <= 5'd13) return "R6";
    else if (op <= 5'd15) return "R7";
    else if (op <= 5'd20) return "R8";
    else if (op == 5'd21) return "R9";
    else if (op == 5'd22) return "R11";
    else if (op == 5'd23) return "R10";
    else                  return "R13";
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    #50000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    #1 chk("R12", "cc_q reset", {8'h0, cc_q_o}, 16'h0050);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {op_i, a_i, b_i, cc_i} = VEC[i][60:32];
      #1;
      chk(req_of(op_i), "res", {8'h0, res_o}, {8'h0, VEC[i][31:24]});
      chk(req_of(op_i), "cc_next", {8'h0, cc_next_o}, {8'h0, VEC[i][23:16]});
      chk((op_i == 5'd22 || op_i == 5'd23) ? req_of(op_i) : "R13", "prod",
          prod_o, VEC[i][15:0]);
      chk("R1", "system bits", {13'h0, cc_next_o[7:6], cc_next_o[4]},
          {13'h0, VEC[i][23:22], VEC[i][20]});
    end
    // R12: no strobe during the loop, register held its reset value
    chk("R12", "cc_q held", {8'h0, cc_q_o}, 16'h0050);

    // R12: load on strobe
    @(negedge clk_i);
    op_i = 5'd11; a_i = 8'h77; cc_i = 8'hAB; upd_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R12", "cc_q load clr", {8'h0, cc_q_o}, 16'h00A4);
    @(negedge clk_i);
    op_i = 5'd12; a_i = 8'h00; cc_i = 8'h00; upd_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 chk("R12", "cc_q hold", {8'h0, cc_q_o}, 16'h00A4);
    @(negedge clk_i);
    upd_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R12", "cc_q load com", {8'h0, cc_q_o}, 16'h0009);
    @(negedge clk_i);
    upd_i = 1'b0;

    // R12: async reset restores value
    rst_ni = 1'b0; #1;
    chk("R12", "cc_q async reset", {8'h0, cc_q_o}, 16'h0050);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule